// File: doc/BRIEF.md
# Isochronous Resource Lock Unit

This block holds the four shared registers that an isochronous resource manager exposes on a serial bus: the elected bus manager's node number, the remaining isochronous bandwidth, and the two halves of the 64-channel availability bitmap. It serves atomic compare-swap lock requests against them. A lock can address one 32-bit register, or both channel halves at once as a single 64-bit word. The four registers share one update path, and each register answers by its own rule. The manager node is a plain compare-swap. Bandwidth uses an allocate/release rule that keeps the pool within 13 bits. The channel bitmaps apply a masked toggle of only the bits that the request changes. Channel 31, the broadcast channel and the least significant bit of the high half, can never be released.

Requests enter on a valid/ready port and results leave on a valid/ready port. The unit holds at most one lock at a time. `req_ready` is high only when nothing is in flight. Once the request handshake completes, `rsp_valid` rises exactly two clock edges later. The response then holds `rsp_old` and `rsp_code` steady until `rsp_ready` is seen high at a clock edge. A master may keep `req_valid` asserted through a stalled response, and the request is then taken in the cycle after the response is consumed. Packet parsing, plain reads and any other register fall outside this block.

Top module: `irm_lock_unit`

## Requirements
- R1: After reset the manager register is 0x3F, bandwidth is 4915, the channel-high half is 0xFFFFFFFE and the channel-low half is 0xFFFFFFFF. `req_ready` is 1 and `rsp_valid` is 0.
- R2: `req_ready` is low from the accepting edge until the edge at which the response is taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_old` and `rsp_code` do not change.
- R3: `rsp_valid` rises exactly two clock edges after the edge where `req_valid` and `req_ready` are both high.
- R4: A request with `req_write`=1, with an extended code other than 4'h2 (compare-swap), or with `req_wide`=1 and a select other than 2 returns `rsp_code`=1 (type error) with `rsp_old`=0 and changes no register. Otherwise `rsp_code`=0.
- R5: Select 0 (manager) returns the old value and loads data[31:0] only when the old value equals arg[31:0].
- R6: Select 1 (bandwidth) with arg above 0x1FFF returns the old value and changes nothing.
- R7: Bandwidth, with data masked to its low 13 bits and arg >= data: when arg-data does not exceed the current value, that amount is subtracted and arg is returned. Otherwise the old value is returned and nothing changes.
- R8: Bandwidth with arg < data: when current+(data-arg) stays below 0x2000, the amount is added and arg is returned. Otherwise the old value is returned and nothing changes.
- R9: Selects 2 (high half) and 3 (low half) use affected = arg^data. When arg and the register agree on every affected bit, the affected bits are toggled and arg is returned. Otherwise the register's current value is returned and nothing changes.
- R10: On any lock that touches the high half, bit 0 of the incoming high data (channel 31) is cleared before the channel rule, so that bit of the register stays 0.
- R11: A 64-bit lock (`req_wide`=1, select 2) applies the channel rule of R9 to {high, low} in one step, with arg and data as {bits 63:32 high, 31:0 low}, and returns the old or arg 64-bit value. Narrow results return on bits 31:0 with bits 63:32 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lock request present |
| req_ready | output | 1 | Unit idle; request taken when both high |
| req_sel | input | 2 | Register: 0 manager, 1 bandwidth, 2 channel high, 3 channel low |
| req_code | input | 4 | Extended lock code, 4'h2 = compare-swap |
| req_write | input | 1 | Plain write attempt (always a type error) |
| req_wide | input | 1 | 64-bit lock across both channel halves |
| req_data | input | 64 | New value / data operand |
| req_arg | input | 64 | Compare / arg operand |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when both high |
| rsp_old | output | 64 | Returned value |
| rsp_code | output | 2 | 0 complete, 1 type error |

## Verification
Two events can land on the same edge: the consumption of a response, and a fresh request held on the input since that response was stalled. The bench keeps `req_valid` asserted across responses while a pattern of `rsp_ready` stalls back-pressures the unit. A behavioural model then judges, on every falling edge, the cycle in which `req_ready` returns and the cycle in which the next request is accepted. The same model predicts each returned value, so channel-31 protection inside a 64-bit lock is judged against narrow locks on the same half.

// File: rtl/irm_pkg.sv
package irm_pkg;

  localparam int unsigned CODE_W = 4;
  localparam logic [CODE_W-1:0] XC_CMP_SWAP = 4'h2;

  typedef enum logic [1:0] {
    SEL_MGR   = 2'd0,
    SEL_BW    = 2'd1,
    SEL_CH_HI = 2'd2,
    SEL_CH_LO = 2'd3
  } irm_sel_e;

  typedef enum logic [1:0] {
    RC_COMPLETE = 2'd0,
    RC_TYPE_ERR = 2'd1
  } irm_rc_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_EXEC = 2'd1,
    PH_RESP = 2'd2
  } irm_phase_e;

endpackage

// File: rtl/irm_handshake.sv
module irm_handshake
  import irm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic take_o,
  output logic exec_o,
  output logic out_valid,
  input  logic out_ready
);

  irm_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (in_valid) phase_d = PH_EXEC;
      PH_EXEC: phase_d = PH_RESP;
      PH_RESP: if (out_ready) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign in_ready  = (phase_q == PH_IDLE);
  assign take_o    = in_valid && in_ready;
  assign exec_o    = (phase_q == PH_EXEC);
  assign out_valid = (phase_q == PH_RESP);

  // R2: an exec cycle is always followed by a response cycle
  a_r2_exec_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> out_valid);

endmodule

// File: rtl/irm_bw_alu.sv
module irm_bw_alu #(
  parameter int unsigned W    = 32,
  parameter int unsigned BW_W = 13
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] arg_i,
  output logic         ok_o,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] ret_o
);

  localparam logic [W-1:0] LIMIT = W'(1) << BW_W;
  localparam logic [W-1:0] MASK  = LIMIT - W'(1);

  logic [W-1:0] data_m;
  logic         arg_in_range;
  logic         grab;
  logic [W-1:0] amount;
  logic [W:0]   grown;
  logic         fits;

  assign data_m       = data_i & MASK;
  assign arg_in_range = (arg_i < LIMIT);
  assign grab         = (arg_i >= data_m);
  assign amount       = grab ? (arg_i - data_m) : (data_m - arg_i);
  assign grown        = {1'b0, cur_i} + {1'b0, amount};
  assign fits         = grab ? (cur_i >= amount) : (grown < {1'b0, LIMIT});

  assign ok_o  = arg_in_range && fits;
  assign ret_o = ok_o ? arg_i : cur_i;

  always_comb begin
    nxt_o = cur_i;
    if (ok_o) begin
      if (grab) nxt_o = cur_i - amount;
      else      nxt_o = grown[W-1:0];
    end
  end

endmodule

// File: rtl/irm_chan_alu.sv
module irm_chan_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] arg_i,
  output logic         ok_o,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] ret_o
);

  logic [W-1:0] flip;

  assign flip  = arg_i ^ data_i;
  assign ok_o  = ((arg_i ^ cur_i) & flip) == '0;
  assign nxt_o = ok_o ? (cur_i ^ flip) : cur_i;
  assign ret_o = ok_o ? arg_i : cur_i;

endmodule

// File: rtl/irm_lock_unit.sv
module irm_lock_unit
  import irm_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BW_W       = 13,
  parameter int unsigned BW_RESET   = 4915,
  parameter int unsigned MGR_RESET  = 63,
  parameter bit          KEEP_BCAST = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_sel,
  input  logic [3:0]          req_code,
  input  logic                req_write,
  input  logic                req_wide,
  input  logic [2*DATA_W-1:0] req_data,
  input  logic [2*DATA_W-1:0] req_arg,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*DATA_W-1:0] rsp_old,
  output logic [1:0]          rsp_code
);

  localparam int unsigned WW = 2 * DATA_W;
  localparam logic [DATA_W-1:0] ONE_N     = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] CH_HI_RST = ~ONE_N;
  localparam logic [DATA_W-1:0] CH_LO_RST = '1;
  localparam logic [DATA_W-1:0] BW_RST    = DATA_W'(BW_RESET);
  localparam logic [DATA_W-1:0] MGR_RST   = DATA_W'(MGR_RESET);
  localparam logic [DATA_W-1:0] BW_LIMIT  = DATA_W'(1) << BW_W;

  // handshake sequencing
  logic take, exec;

  irm_handshake i_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .take_o    (take),
    .exec_o    (exec),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready)
  );

  // captured request
  irm_sel_e          q_sel;
  logic [3:0]        q_code;
  logic              q_write;
  logic              q_wide;
  logic [WW-1:0]     q_data;
  logic [WW-1:0]     q_arg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_sel   <= SEL_MGR;
      q_code  <= '0;
      q_write <= 1'b0;
      q_wide  <= 1'b0;
      q_data  <= '0;
      q_arg   <= '0;
    end else if (take) begin
      q_sel   <= irm_sel_e'(req_sel);
      q_code  <= req_code;
      q_write <= req_write;
      q_wide  <= req_wide;
      q_data  <= req_data;
      q_arg   <= req_arg;
    end
  end

  // resource registers
  logic [DATA_W-1:0] mgr_q, bw_q, chhi_q, chlo_q;

  // request legality
  logic bad_req;
  assign bad_req = q_write || (q_code != XC_CMP_SWAP) ||
                   (q_wide && (q_sel != SEL_CH_HI));

  // broadcast channel guard on the high half
  logic [DATA_W-1:0] hi_guard;
  generate
    if (KEEP_BCAST) begin : g_keep_bcast
      assign hi_guard = ~ONE_N;
    end else begin : g_free_bcast
      assign hi_guard = '1;
    end
  endgenerate

  // bandwidth path
  logic              bw_ok;
  logic [DATA_W-1:0] bw_nxt, bw_ret;

  irm_bw_alu #(.W(DATA_W), .BW_W(BW_W)) i_bw (
    .cur_i  (bw_q),
    .data_i (q_data[DATA_W-1:0]),
    .arg_i  (q_arg[DATA_W-1:0]),
    .ok_o   (bw_ok),
    .nxt_o  (bw_nxt),
    .ret_o  (bw_ret)
  );

  // narrow channel path
  logic              n_ok;
  logic [DATA_W-1:0] n_cur, n_data, n_nxt, n_ret;

  assign n_cur  = (q_sel == SEL_CH_HI) ? chhi_q : chlo_q;
  assign n_data = q_data[DATA_W-1:0] & ((q_sel == SEL_CH_HI) ? hi_guard : '1);

  irm_chan_alu #(.W(DATA_W)) i_chan_n (
    .cur_i  (n_cur),
    .data_i (n_data),
    .arg_i  (q_arg[DATA_W-1:0]),
    .ok_o   (n_ok),
    .nxt_o  (n_nxt),
    .ret_o  (n_ret)
  );

  // wide channel path
  logic          w_ok;
  logic [WW-1:0] w_cur, w_data, w_nxt, w_ret;

  assign w_cur  = {chhi_q, chlo_q};
  assign w_data = {q_data[WW-1:DATA_W] & hi_guard, q_data[DATA_W-1:0]};

  irm_chan_alu #(.W(WW)) i_chan_w (
    .cur_i  (w_cur),
    .data_i (w_data),
    .arg_i  (q_arg),
    .ok_o   (w_ok),
    .nxt_o  (w_nxt),
    .ret_o  (w_ret)
  );

  // result selection
  logic [WW-1:0] res_old;
  irm_rc_e       res_rc;

  always_comb begin
    res_old = '0;
    res_rc  = RC_COMPLETE;
    if (bad_req) begin
      res_rc = RC_TYPE_ERR;
    end else if (q_wide) begin
      res_old = w_ret;
    end else begin
      unique case (q_sel)
        SEL_MGR:   res_old = {{DATA_W{1'b0}}, mgr_q};
        SEL_BW:    res_old = {{DATA_W{1'b0}}, bw_ret};
        SEL_CH_HI,
        SEL_CH_LO: res_old = {{DATA_W{1'b0}}, n_ret};
        default:   res_old = '0;
      endcase
    end
  end

  // register update, one exec cycle per lock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mgr_q  <= MGR_RST;
      bw_q   <= BW_RST;
      chhi_q <= CH_HI_RST;
      chlo_q <= CH_LO_RST;
    end else if (exec && !bad_req) begin
      if (q_wide) begin
        if (w_ok) begin
          chhi_q <= w_nxt[WW-1:DATA_W];
          chlo_q <= w_nxt[DATA_W-1:0];
        end
      end else begin
        unique case (q_sel)
          SEL_MGR:   if (mgr_q == q_arg[DATA_W-1:0]) mgr_q <= q_data[DATA_W-1:0];
          SEL_BW:    if (bw_ok) bw_q <= bw_nxt;
          SEL_CH_HI: if (n_ok) chhi_q <= n_nxt;
          SEL_CH_LO: if (n_ok) chlo_q <= n_nxt;
          default: ;
        endcase
      end
    end
  end

  // response register, held through back-pressure
  logic [WW-1:0] old_q;
  logic [1:0]    rc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      old_q <= '0;
      rc_q  <= RC_COMPLETE;
    end else if (exec) begin
      old_q <= res_old;
      rc_q  <= res_rc;
    end
  end

  assign rsp_old  = old_q;
  assign rsp_code = rc_q;

  // R2: response stays put while stalled
  a_r2_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_old) && $stable(rsp_code));

  // R2: nothing accepted while a response is pending
  a_r2_single_flight: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R3: fixed two-edge latency from acceptance
  a_r3_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready, 2));

  // R4: a rejected lock leaves every resource register alone
  a_r4_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && rsp_code == RC_TYPE_ERR) |->
      $stable(mgr_q) && $stable(bw_q) && $stable(chhi_q) && $stable(chlo_q));

  // R7/R8: bandwidth pool never leaves its 13-bit range
  a_r8_bw_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bw_q < BW_LIMIT);

  // R10: broadcast channel stays allocated
  generate
    if (KEEP_BCAST) begin : g_chk_bcast
      a_r10_ch31_held: assert property (@(posedge clk) disable iff (!rst_n)
        chhi_q[0] == 1'b0);
    end
  endgenerate

endmodule

// File: tb/test_irm_lock_unit.sv
`timescale 1ns/1ps
module test_irm_lock_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_sel = '0;
  logic [3:0]  req_code = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [63:0] req_data = '0;
  logic [63:0] req_arg = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_old;
  logic [1:0]  rsp_code;

  always #2.5 clk = ~clk;

  irm_lock_unit i_irm_lock_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .req_code(req_code), .req_write(req_write),
    .req_wide(req_wide), .req_data(req_data), .req_arg(req_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_old(rsp_old), .rsp_code(rsp_code)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural reference state
  logic [31:0] m_mgr, m_bw, m_hi, m_lo;
  int          m_phase;
  logic        m_acc;
  logic [63:0] m_old;
  logic [1:0]  m_rc;
  string       m_tag;
  bit          stall_mode = 1'b0;
  int          cyc = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mgr = 32'h3F; m_bw = 32'd4915; m_hi = 32'hFFFF_FFFE; m_lo = 32'hFFFF_FFFF;
    m_phase = 0; m_acc = 1'b0; m_old = '0; m_rc = 2'd0; m_tag = "R1";
  endtask

  task automatic model_lock();
    logic [31:0] a, d, amt;
    logic [63:0] cat, dd, flip;
    m_rc = 2'd0; m_old = '0;
    a = req_arg[31:0];
    d = req_data[31:0];
    if (req_write || req_code != 4'h2 || (req_wide && req_sel != 2'd2)) begin
      m_rc = 2'd1; m_tag = "R4";
    end else if (req_wide) begin
      m_tag = "R11";
      cat = {m_hi, m_lo};
      dd = req_data; dd[32] = 1'b0;
      flip = req_arg ^ dd;
      if ((req_arg & flip) == (cat & flip)) begin
        cat = cat ^ flip; m_old = req_arg;
        m_hi = cat[63:32]; m_lo = cat[31:0];
      end else m_old = cat;
    end else begin
      case (req_sel)
        2'd0: begin
          m_tag = "R5"; m_old = {32'd0, m_mgr};
          if (m_mgr == a) m_mgr = d;
        end
        2'd1: begin
          d = d & 32'h1FFF;
          m_old = {32'd0, m_bw};
          if (a > 32'h1FFF) m_tag = "R6";
          else if (a >= d) begin
            m_tag = "R7"; amt = a - d;
            if (m_bw >= amt) begin m_bw = m_bw - amt; m_old = {32'd0, a}; end
          end else begin
            m_tag = "R8"; amt = d - a;
            if (m_bw + amt < 32'h2000) begin m_bw = m_bw + amt; m_old = {32'd0, a}; end
          end
        end
        2'd2: begin
          m_tag = "R10"; d[0] = 1'b0;
          if (((a ^ m_hi) & (a ^ d)) == 0) begin m_hi = m_hi ^ (a ^ d); m_old = {32'd0, a}; end
          else m_old = {32'd0, m_hi};
        end
        default: begin
          m_tag = "R9";
          if (((a ^ m_lo) & (a ^ d)) == 0) begin m_lo = m_lo ^ (a ^ d); m_old = {32'd0, a}; end
          else m_old = {32'd0, m_lo};
        end
      endcase
    end
  endtask

  // per-clock comparison at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      model_reset();
    end else begin
      m_acc = 1'b0;
      case (m_phase)
        0: if (req_valid) begin model_lock(); m_phase = 1; m_acc = 1'b1; end
        1: m_phase = 2;
        default: if (rsp_ready) m_phase = 0;
      endcase
      check("R2 req_ready", {63'd0, req_ready}, {63'd0, m_phase == 0});
      check("R3 rsp_valid", {63'd0, rsp_valid}, {63'd0, m_phase == 2});
      if (m_phase == 2 && rsp_valid) begin
        check({m_tag, " rsp_old"}, rsp_old, m_old);
        check({m_tag, " rsp_code"}, {62'd0, rsp_code}, {62'd0, m_rc});
      end
    end
  end

  // response back-pressure pattern
  initial begin
    forever begin
      @(negedge clk); #1;
      rsp_ready = stall_mode ? ((cyc % 5) != 3 && (cyc % 7) != 2) : 1'b1;
    end
  end

  task automatic send(input logic [1:0] sel, input logic [3:0] code, input logic wr,
                      input logic wide, input logic [63:0] d, input logic [63:0] a);
    @(negedge clk); #1;
    req_sel = sel; req_code = code; req_write = wr; req_wide = wide;
    req_data = d; req_arg = a; req_valid = 1'b1;
    do begin @(negedge clk); #1; end while (!m_acc);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (m_phase != 0) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle ports during reset
    check("R1 req_ready in reset", {63'd0, req_ready}, 64'd1);
    check("R1 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    #1 rst_n = 1'b1;

    // R1/R5: manager reset value seen by a missing compare, then swaps
    send(2'd0, 4'h2, 0, 0, 64'd5, 64'd0);
    send(2'd0, 4'h2, 0, 0, 64'd2, 64'h3F);
    send(2'd0, 4'h2, 0, 0, 64'd7, 64'd2);
    // R4: illegal forms
    send(2'd1, 4'h3, 0, 0, 64'd0, 64'd4915);
    send(2'd1, 4'h2, 1, 0, 64'd0, 64'd4915);
    send(2'd1, 4'h2, 0, 1, 64'd0, 64'd4915);
    // R6: out-of-range arg
    send(2'd1, 4'h2, 0, 0, 64'd0, 64'h2000);
    // R7: allocate, exhaust, overdraw
    send(2'd1, 4'h2, 0, 0, 64'd4815, 64'd4915);
    send(2'd1, 4'h2, 0, 0, 64'd0, 64'd4815);
    send(2'd1, 4'h2, 0, 0, 64'd0, 64'd10);
    // R8: release to the top (upper data bits masked), then overflow
    send(2'd1, 4'h2, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    send(2'd1, 4'h2, 0, 0, 64'd1, 64'd0);
    // R9: low half allocate, repeat fails
    send(2'd3, 4'h2, 0, 0, 64'hFFFF_FFFE, 64'hFFFF_FFFF);
    send(2'd3, 4'h2, 0, 0, 64'hFFFF_FFFE, 64'hFFFF_FFFF);
    // R10: release of channel 31 suppressed, then observed via mismatch
    send(2'd2, 4'h2, 0, 0, 64'hFFFF_FFFF, 64'hFFFF_FFFE);
    send(2'd2, 4'h2, 0, 0, 64'hFFFF_FFFF, 64'h0);
    // R11: wide lock, including a channel-31 release attempt
    send(2'd2, 4'h2, 0, 1, 64'h7FFF_FFFF_7FFF_FFFF, 64'hFFFF_FFFE_FFFF_FFFE);
    send(2'd2, 4'h2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFE_7FFF_FFFE);
    send(2'd2, 4'h2, 0, 1, 64'h0, 64'h0123_4567_89AB_CDEF);
    drain();

    // R2/R3: back-pressure with requests held across stalled responses
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [1:0]  s;
      logic [63:0] a, d;
      int          k;
      s = 2'($urandom_range(0, 3));
      k = $urandom_range(0, 31);
      case (s)
        2'd0: begin a = {32'd0, ($urandom_range(0, 1) != 0) ? m_mgr : 32'($urandom)}; d = {32'd0, 32'($urandom)}; end
        2'd1: begin a = {32'd0, m_bw}; d = {32'd0, 32'($urandom_range(0, 8191))}; end
        2'd2: begin a = {32'd0, m_hi}; d = a ^ (64'd1 << k); end
        default: begin a = {32'd0, m_lo}; d = a ^ (64'd1 << k); end
      endcase
      if (i % 17 == 5) send(2'd2, 4'h2, 0, 1, {m_hi, m_lo} ^ (64'd1 << (k + 16)), {m_hi, m_lo});
      else if (i % 23 == 7) send(s, 4'h0, 0, 0, d, a);
      else send(s, 4'h2, 0, 0, d, a);
    end
    drain();
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule